// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits at the output side of a system clock generator. It takes an internal CPU-rate clock and an internal free-running PCI-rate clock and derives three groups of outputs from them. These are a bank of gated CPU clocks, a bank of gated PCI clocks, and one free-running PCI clock. Three active-low asynchronous controls act on these outputs. One parks the CPU bank. One parks the PCI bank. The third puts the whole generator into power-down.

Every gated output is formed by an enable flop that updates on the falling edge of its source clock, so a gate opens or closes only while the clock is low. As a result, no pulse is ever shortened. Stopped outputs always sit low. The power-down sequencer runs in the free-running PCI domain and drives the oscillator, VCO and reference-output enables. After power-down is released, it waits a programmable number of PCI cycles, standing in for the oscillator settling time, before any gate reopens.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is asserted, every gated CPU, PCI and free-running output is low, the reference enable is low, and the oscillator and VCO enables are high.
- R2: After reset is released on a PCI rising edge, the free-running PCI output produces its first pulse on PCI rising edge WAKE_CYC+1, counted from that edge. The PCI bank starts on the same edge when PCI stop is high.
- R3: When CPU stop goes low just after a CPU rising edge, the CPU outputs still pulse on the next two CPU rising edges and then stay low. The free-running PCI, PCI bank and reference outputs keep running.
- R4: When CPU stop goes high just after a CPU rising edge, the first CPU pulse appears on the 6th following CPU rising edge. This is two synchronizer edges followed by at least three idle CPU cycles.
- R5: PCI stop going low just after a PCI rising edge leaves exactly two more PCI-bank pulses. Once it goes high again, the first PCI-bank pulse returns on the 3rd PCI rising edge. The free-running PCI and CPU outputs are unaffected throughout.
- R6: Power-down going low just after a PCI rising edge has the following effects. The free-running PCI output pulses on the next two PCI edges only. The reference enable is low after the 2nd edge. The oscillator and VCO enables are low after the 3rd edge. The CPU outputs are low from the following CPU edges on.
- R7: Power-down going high just after a PCI rising edge has the following effects. The oscillator and VCO enables return after the 3rd PCI edge. The reference enable returns after edge WAKE_CYC+3. The first free-running PCI pulse appears on edge WAKE_CYC+4.
- R8: Power-down overrides both stop inputs, so every output stays low whatever they do. On wake-up, each gated bank follows the current level of its stop input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_in | input | 1 | Internal CPU-rate clock |
| pci_clk_in | input | 1 | Internal free-running PCI-rate clock |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU bank stop |
| pci_stop_n | input | 1 | Asynchronous active-low PCI bank stop |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| cpu_clk_out | output | N_CPU | Gated CPU clocks, park low |
| pci_clk_out | output | N_PCI | Gated PCI clocks, park low |
| pci_free_out | output | 1 | Free-running PCI clock, stopped only by power-down |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| ref_en | output | 1 | Reference output enable |

## Verification
Each control is toggled on its own, just after a rising edge of the clock that samples it. Counting pulses edge by edge then separates the synchronizer depth, the restart hold-off and the negative-edge enable update, because each contributes a different number of edges.

The stop tests also watch the banks that must keep running, which exposes any cross-coupling between the gates. The power-down tests do two things. They toggle the stop inputs while the block is down, and they hold them at chosen levels through wake-up. Together these show whether power-down truly overrides the stops and whether each bank resumes from the live input level rather than a stale one. The wake-up pulse index also pins down the settle counter's length.

// File: rtl/ckctl_pkg.sv
`timescale 1ns/1ps
package ckctl_pkg;
  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_WAKE = 2'd1,
    PS_RUN  = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/ckctl_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer with a chosen reset level.
module ckctl_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = (sh_q << 1) | STAGES'(d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ckctl_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate: the enable moves only on the falling edge.
module ckctl_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_d,
  output logic gclk
);
  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/ckctl_cpu_hold.sv
`timescale 1ns/1ps
// Holds the CPU bank closed for RESTART_CYC cycles after the stop clears.
module ckctl_cpu_hold #(
  parameter int RESTART_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  output logic ok
);
  localparam int RW = $clog2(RESTART_CYC + 1);
  localparam logic [RW-1:0] FULL = RW'(RESTART_CYC);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_d;

  always_comb begin
    if (!run_s)             cnt_d = '0;
    else if (cnt_q != FULL) cnt_d = cnt_q + RW'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok = run_s && (cnt_q == FULL);

  // R4: a fresh release never opens the gate on the following cycle
  assert_restart_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_s) |=> !ok);
endmodule

// File: rtl/ckctl_pwr_seq.sv
`timescale 1ns/1ps
// Power-down sequencer in the free-running PCI domain.
module ckctl_pwr_seq
  import ckctl_pkg::*;
#(
  parameter int WAKE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_s,
  output logic gates_open,
  output logic osc_en,
  output logic vco_en,
  output logic ref_en
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  pwr_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_RUN: begin
        if (!pd_s) state_d = PS_DOWN;
      end
      PS_DOWN: begin
        cnt_d = '0;
        if (pd_s) state_d = PS_WAKE;
      end
      PS_WAKE: begin
        if (!pd_s) begin
          state_d = PS_DOWN;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = PS_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        state_d = PS_DOWN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gates_open = (state_q == PS_RUN) && pd_s;
  assign ref_en     = (state_q == PS_RUN) && pd_s;
  assign osc_en     = (state_q != PS_DOWN);
  assign vco_en     = (state_q != PS_DOWN);

  // R6: a synchronized power-down always lands the sequencer in DOWN
  assert_down_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_s |=> (state_q == PS_DOWN));

  // R7: RUN is only ever entered from the settle wait
  assert_run_via_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && $past(state_q) != PS_RUN) |-> ($past(state_q) == PS_WAKE));
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int N_CPU       = 2,
  parameter int N_PCI       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_CYC = 3,
  parameter int WAKE_CYC    = 100000
) (
  input  logic             rst_n,
  input  logic             cpu_clk_in,
  input  logic             pci_clk_in,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn_n,
  output logic [N_CPU-1:0] cpu_clk_out,
  output logic [N_PCI-1:0] pci_clk_out,
  output logic             pci_free_out,
  output logic             osc_en,
  output logic             vco_en,
  output logic             ref_en
);
  logic pd_s, ps_s, cs_s;
  logic gates_open, cpu_ok;
  logic cpu_en_d, pci_en_d, free_en_d;

  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(pci_clk_in), .rst_n(rst_n), .d(pwr_dn_n), .q(pd_s));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ps_sync (
    .clk(pci_clk_in), .rst_n(rst_n), .d(pci_stop_n), .q(ps_s));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(cpu_clk_in), .rst_n(rst_n), .d(cpu_stop_n), .q(cs_s));

  ckctl_pwr_seq #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk(pci_clk_in), .rst_n(rst_n), .pd_s(pd_s), .gates_open(gates_open),
    .osc_en(osc_en), .vco_en(vco_en), .ref_en(ref_en));

  ckctl_cpu_hold #(.RESTART_CYC(RESTART_CYC)) u_cpu_hold (
    .clk(cpu_clk_in), .rst_n(rst_n), .run_s(cs_s), .ok(cpu_ok));

  // Enable requests; power-down (gates_open) dominates both stops.
  always_comb begin
    cpu_en_d  = gates_open & cpu_ok;
    pci_en_d  = gates_open & ps_s;
    free_en_d = gates_open;
  end

  for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu
    ckctl_gate u_gate (.clk(cpu_clk_in), .rst_n(rst_n), .en_d(cpu_en_d),
                       .gclk(cpu_clk_out[gi]));
  end

  for (genvar gj = 0; gj < N_PCI; gj++) begin : g_pci
    ckctl_gate u_gate (.clk(pci_clk_in), .rst_n(rst_n), .en_d(pci_en_d),
                       .gclk(pci_clk_out[gj]));
  end

  ckctl_gate u_free_gate (.clk(pci_clk_in), .rst_n(rst_n), .en_d(free_en_d),
                          .gclk(pci_free_out));

  // R3: a closed CPU request leaves every CPU output low for the next high phase
  assert_cpu_park_R3: assert property (@(negedge cpu_clk_in) disable iff (!rst_n)
    !$past(cpu_en_d) |-> (cpu_clk_out == '0));

  // R5: a synchronized PCI stop keeps the PCI bank low
  assert_pci_park_R5: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
    !$past(ps_s) |-> (pci_clk_out == '0));

  // R6: power-down silences the free-running output and the PCI bank
  assert_pd_quiet_R6: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
    !$past(gates_open) |-> (!pci_free_out && pci_clk_out == '0));

  // R8: outside RUN the CPU bank never pulses, whatever CPU stop does
  assert_pd_cpu_R8: assert property (@(negedge cpu_clk_in) disable iff (!rst_n)
    (!$past(gates_open) && !gates_open) |-> (cpu_clk_out == '0));
endmodule

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  localparam int WAKE  = 16;
  localparam int NC    = 2;
  localparam int NP    = 5;

  logic rst_n, cpu_clk, pci_clk, cpu_stop_n, pci_stop_n, pwr_dn_n;
  logic [NC-1:0] cpu_out;
  logic [NP-1:0] pci_out;
  logic free_out, osc_en, vco_en, ref_en;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .WAKE_CYC(WAKE)) u_clk_stop_ctrl (
    .rst_n(rst_n), .cpu_clk_in(cpu_clk), .pci_clk_in(pci_clk),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
    .cpu_clk_out(cpu_out), .pci_clk_out(pci_out), .pci_free_out(free_out),
    .osc_en(osc_en), .vco_en(vco_en), .ref_en(ref_en));

  // 200 MHz CPU-rate clock; PCI-rate clock at one third, rising edges aligned
  initial begin
    cpu_clk = 1'b0;
    forever #2.5 cpu_clk = ~cpu_clk;
  end
  initial begin
    pci_clk = 1'b0;
    forever #7.5 pci_clk = ~pci_clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pedge();
    @(posedge pci_clk);
    #1;
  endtask

  task automatic cedge();
    @(posedge cpu_clk);
    #1;
  endtask

  task automatic t_reset();
    int first;
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dn_n = 1'b1;
    repeat (4) cedge();
    chk("R1 cpu_out in reset", int'(cpu_out), 0);
    chk("R1 pci_out in reset", int'(pci_out), 0);
    chk("R1 free_out in reset", int'(free_out), 0);
    chk("R1 ref_en in reset", int'(ref_en), 0);
    chk("R1 osc_en/vco_en in reset", int'({osc_en, vco_en}), 3);
    @(posedge pci_clk); #1; rst_n = 1'b1;
    first = 0;
    for (int k = 1; k <= WAKE + 6; k++) begin
      pedge();
      if (free_out && first == 0) begin
        first = k;
        chk("R2 pci bank starts with free", int'(pci_out), 31);
      end
    end
    chk("R2 first free pulse after reset", first, WAKE + 1);
  endtask

  task automatic t_cpu_stop();
    int cnt, last, fcnt;
    repeat (8) cedge();
    @(posedge cpu_clk); #1; cpu_stop_n = 1'b0;
    cnt = 0; last = 0;
    for (int k = 1; k <= 9; k++) begin
      cedge();
      if (cpu_out == 2'b11) begin cnt++; last = k; end
      else chk("R3 cpu bits agree", int'(cpu_out), 0);
    end
    chk("R3 cpu pulses after stop", cnt, 2);
    chk("R3 last cpu pulse edge", last, 2);
    fcnt = 0;
    for (int k = 1; k <= 6; k++) begin
      pedge();
      if (free_out && pci_out == 5'b11111 && ref_en) fcnt++;
    end
    chk("R3 pci/free/ref keep running", fcnt, 6);
  endtask

  task automatic t_cpu_start();
    int first, cnt;
    @(posedge cpu_clk); #1; cpu_stop_n = 1'b1;
    first = 0; cnt = 0;
    for (int k = 1; k <= 12; k++) begin
      cedge();
      if (cpu_out != 0) begin
        if (first == 0) first = k;
        cnt++;
      end
    end
    chk("R4 first cpu pulse after release", first, 6);
    chk("R4 cpu pulses every edge once running", cnt, 7);
  endtask

  task automatic t_pci_stop();
    int cnt, last, fcnt, ccnt, first;
    @(posedge pci_clk); #1; pci_stop_n = 1'b0;
    cnt = 0; last = 0; fcnt = 0; ccnt = 0;
    for (int k = 1; k <= 8; k++) begin
      pedge();
      if (pci_out == 5'b11111) begin cnt++; last = k; end
      if (free_out) fcnt++;
      if (cpu_out == 2'b11) ccnt++;
    end
    chk("R5 pci pulses after stop", cnt, 2);
    chk("R5 last pci pulse edge", last, 2);
    chk("R5 free runs through pci stop", fcnt, 8);
    chk("R5 cpu runs through pci stop", ccnt, 8);
    @(posedge pci_clk); #1; pci_stop_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      pedge();
      if (pci_out != 0 && first == 0) first = k;
    end
    chk("R5 first pci pulse after release", first, 3);
  endtask

  task automatic t_pwr_down();
    int fcnt, last, ccnt;
    @(posedge pci_clk); #1; pwr_dn_n = 1'b0;
    fcnt = 0; last = 0;
    for (int k = 1; k <= 8; k++) begin
      pedge();
      if (free_out) begin fcnt++; last = k; end
      if (k == 1) chk("R6 ref_en still on at edge 1", int'(ref_en), 1);
      if (k == 2) begin
        chk("R6 ref_en off at edge 2", int'(ref_en), 0);
        chk("R6 osc/vco still on at edge 2", int'({osc_en, vco_en}), 3);
      end
      if (k == 3) chk("R6 osc/vco off at edge 3", int'({osc_en, vco_en}), 0);
      if (k >= 3) chk("R6 pci bank low", int'(pci_out), 0);
    end
    chk("R6 free pulses after power-down", fcnt, 2);
    chk("R6 last free pulse edge", last, 2);
    ccnt = 0;
    for (int k = 1; k <= 6; k++) begin
      cedge();
      if (cpu_out != 0) ccnt++;
    end
    chk("R6 cpu bank low in power-down", ccnt, 0);
  endtask

  task automatic t_override_wake();
    int act, first, pcnt;
    // stops toggled while down: nothing may move (R8)
    pci_stop_n = 1'b0;
    cpu_stop_n = 1'b0;
    act = 0;
    for (int k = 1; k <= 4; k++) begin
      pedge();
      if (free_out || pci_out != 0 || cpu_out != 0) act++;
    end
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      pedge();
      if (free_out || pci_out != 0 || cpu_out != 0) act++;
    end
    pci_stop_n = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      pedge();
      if (free_out || pci_out != 0 || cpu_out != 0) act++;
    end
    chk("R8 outputs quiet while stops toggle in power-down", act, 0);
    // wake with pci stop held low, cpu stop high
    @(posedge pci_clk); #1; pwr_dn_n = 1'b1;
    first = 0; pcnt = 0;
    for (int k = 1; k <= WAKE + 8; k++) begin
      pedge();
      if (k == 2) chk("R7 osc/vco still off at edge 2", int'({osc_en, vco_en}), 0);
      if (k == 3) chk("R7 osc/vco on at edge 3", int'({osc_en, vco_en}), 3);
      if (k == WAKE + 2) chk("R7 ref_en off before settle end", int'(ref_en), 0);
      if (k == WAKE + 3) chk("R7 ref_en on after settle", int'(ref_en), 1);
      if (free_out && first == 0) first = k;
      if (pci_out != 0) pcnt++;
      if (k == WAKE + 8) chk("R8 cpu bank resumes with stop high", int'(cpu_out), 3);
    end
    chk("R7 first free pulse after wake", first, WAKE + 4);
    chk("R8 pci bank follows held stop after wake", pcnt, 0);
    @(posedge pci_clk); #1; pci_stop_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      pedge();
      if (pci_out != 0 && first == 0) first = k;
    end
    chk("R8 pci bank opens on stop release", first, 3);
  endtask

  task automatic t_wake_cpu_held();
    int ccnt, fcnt;
    cpu_stop_n = 1'b0;
    @(posedge pci_clk); #1; pwr_dn_n = 1'b0;
    repeat (6) pedge();
    @(posedge pci_clk); #1; pwr_dn_n = 1'b1;
    ccnt = 0; fcnt = 0;
    for (int k = 1; k <= WAKE + 10; k++) begin
      pedge();
      if (cpu_out != 0) ccnt++;
      if (free_out) fcnt++;
    end
    chk("R8 cpu bank stays low after wake with stop held", ccnt, 0);
    chk("R8 free clock resumes with cpu stopped", fcnt, 7);
    cpu_stop_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_cpu_stop();
    t_cpu_start();
    t_pci_stop();
    t_pwr_down();
    t_override_wake();
    t_wake_cpu_held();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule